// File: doc/BRIEF.md
# Sign-Magnitude Floating-Point Adder

This block adds two numbers held in a compact floating-point word and hands back their sum in the same word layout. A word is `1 + EXP_W + MANT_W` bits wide. The top bit is the sign, where 1 means negative. The next `EXP_W` bits are an unsigned exponent with a bias of `2^(EXP_W-1)-1`. The low `MANT_W` bits are the mantissa, and its most significant bit is stored explicitly. A normalized mantissa therefore always has bit `MANT_W-1` set, and its value lies in [1,2). The all-zero word stands for zero, and a zero exponent is used for nothing else. With the default parameters (`MANT_W`=8, `EXP_W`=6), the value 1.0 is the word `{0, 6'd31, 8'h80}`.

Internally the block first puts the operand with the larger exponent in front. It then shifts the other operand's mantissa right to line it up. The two mantissas are added in two's complement, and the total is split back into a sign and a magnitude. The magnitude is renormalized in one of two ways: a one-bit right shift when the sum carried out, or a leading-one search followed by a left shift. Bits that fall off either end are dropped. The block never rounds. There are no NaN, infinity or denormal encodings.

Operands enter on a valid/ready stream, and the sum leaves on another. A transfer takes place on a rising clock edge where valid and ready are both high. The sum appears on the output one cycle after the operands are accepted. While `out_valid` is high and `out_ready` is low, the output word stays frozen and `in_ready` is low. When the consumer takes a result, a new operand pair can be accepted on that same edge.

Top module: `fpa_adder`

## Requirements
- R1: The sum does not depend on operand order. When exponents differ, the operand with the larger exponent sets the reference exponent. An all-zero operand acts as the value zero.
- R2: The mantissa of the smaller-exponent operand is shifted right by the exponent difference before the add. Bits shifted below bit 0 are discarded, with no guard or sticky bit.
- R3: When the exponent difference is `MANT_W` or more, the output word equals the larger-exponent operand exactly, sign included.
- R4: Operands of opposite sign are subtracted. The output sign is the sign of the operand with the larger aligned magnitude. Two negative operands give a negative sum.
- R5: When the magnitude reaches 2.0 or more, the mantissa is shifted right by one and the exponent goes up by one. The bit shifted out is discarded.
- R6: When the magnitude is below 1.0 and not zero, the mantissa is shifted left until its leading one sits in bit `MANT_W-1`. The exponent is lowered by the same shift count.
- R7: An exact-zero sum gives the all-zero word, so sign, exponent and mantissa are all 0.
- R8: When renormalization would take the exponent below 1, the output is the all-zero word.
- R9: When a carry would push the exponent past `2^EXP_W-1`, the output saturates to the maximum exponent and an all-ones mantissa. The sign is kept.
- R10: An accepted operand pair shows up with `out_valid` high on the next edge. While `out_valid && !out_ready`, the output stays stable and `in_ready` is low. `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R11: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Adder can take an operand pair |
| in_a | input | 1+EXP_W+MANT_W | First operand {sign, exponent, mantissa} |
| in_b | input | 1+EXP_W+MANT_W | Second operand {sign, exponent, mantissa} |
| out_valid | output | 1 | Sum word held for the consumer |
| out_ready | input | 1 | Consumer takes the sum |
| out_sum | output | 1+EXP_W+MANT_W | Sum {sign, exponent, mantissa} |

## Verification
The checker assumes every operand is well formed: either the all-zero word, or a nonzero exponent paired with a mantissa whose top bit is set. Under that assumption, its normalization and zero-encoding properties say something meaningful. Every operand in the vector table and in the directed tests is built to this rule. The operands cover equal, close and far-apart exponents, opposite signs, exact cancellation, the smallest exponent and the largest exponent. The property for a far-apart exponent gap fires only on accepted pairs whose larger-exponent operand is normalized.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  // Outcome chosen by the renormalizer for one sum
  typedef enum logic [1:0] {
    RES_NORMAL = 2'd0,
    RES_ZERO   = 2'd1,
    RES_SAT    = 2'd2
  } res_kind_e;

endpackage

// File: rtl/fpa_shift.sv
// Logarithmic shifter; direction picked by parameter.
module fpa_shift #(
  parameter int W    = 8,
  parameter int SH_W = 3,
  parameter bit LEFT = 1'b0
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    dout
);

  logic [W-1:0] stage [0:SH_W];

  assign stage[0] = din;

  for (genvar g = 0; g < SH_W; g++) begin : g_stage
    localparam int STEP = 1 << g;
    if (STEP >= W) begin : g_flush
      assign stage[g+1] = amt[g] ? '0 : stage[g];
    end else if (LEFT) begin : g_left
      assign stage[g+1] = amt[g] ? (stage[g] << STEP) : stage[g];
    end else begin : g_right
      assign stage[g+1] = amt[g] ? (stage[g] >> STEP) : stage[g];
    end
  end

  assign dout = stage[SH_W];

endmodule

// File: rtl/fpa_order_align.sv
// Puts the larger-exponent operand first and aligns the other (R1, R2, R3).
module fpa_order_align #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 6
) (
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [MANT_W-1:0] a_mant,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [MANT_W-1:0] b_mant,
  output logic              big_sign,
  output logic [EXP_W-1:0]  big_exp,
  output logic [MANT_W-1:0] big_mant,
  output logic              small_sign,
  output logic [MANT_W-1:0] small_al
);

  localparam int SHA_W = (MANT_W > 1) ? $clog2(MANT_W) : 1;

  logic              swap;
  logic [EXP_W-1:0]  small_exp;
  logic [MANT_W-1:0] small_mant;
  logic [EXP_W-1:0]  diff;
  logic              too_far;
  logic [MANT_W-1:0] shifted;

  assign swap = b_exp > a_exp;

  always_comb begin
    if (swap) begin
      big_sign   = b_sign;
      big_exp    = b_exp;
      big_mant   = b_mant;
      small_sign = a_sign;
      small_exp  = a_exp;
      small_mant = a_mant;
    end else begin
      big_sign   = a_sign;
      big_exp    = a_exp;
      big_mant   = a_mant;
      small_sign = b_sign;
      small_exp  = b_exp;
      small_mant = b_mant;
    end
  end

  assign diff    = big_exp - small_exp;
  // R3: gap of MANT_W or more wipes the smaller mantissa
  assign too_far = 32'(diff) >= 32'(MANT_W);

  fpa_shift #(
    .W   (MANT_W),
    .SH_W(SHA_W),
    .LEFT(1'b0)
  ) u_align (
    .din (small_mant),
    .amt (SHA_W'(diff)),
    .dout(shifted)
  );

  assign small_al = too_far ? '0 : shifted;

endmodule

// File: rtl/fpa_mant_addsub.sv
// Two's-complement mantissa add, back to sign and magnitude (R4).
module fpa_mant_addsub #(
  parameter int MANT_W = 8
) (
  input  logic              big_sign,
  input  logic [MANT_W-1:0] big_mant,
  input  logic              small_sign,
  input  logic [MANT_W-1:0] small_al,
  output logic              res_sign,
  output logic [MANT_W:0]   res_mag
);

  localparam int SW = MANT_W + 2;

  logic [SW-1:0] ext_big;
  logic [SW-1:0] ext_small;
  logic [SW-1:0] op_big;
  logic [SW-1:0] op_small;
  logic [SW-1:0] total;

  assign ext_big   = {2'b00, big_mant};
  assign ext_small = {2'b00, small_al};

  assign op_big   = big_sign   ? (~ext_big + 1'b1)   : ext_big;
  assign op_small = small_sign ? (~ext_small + 1'b1) : ext_small;
  assign total    = op_big + op_small;

  // Magnitude never exceeds 2^(MANT_W+1)-1, so the low bits suffice
  assign res_sign = total[SW-1];
  assign res_mag  = res_sign ? (~total[MANT_W:0] + 1'b1) : total[MANT_W:0];

endmodule

// File: rtl/fpa_lead_one.sv
// Position of the most significant set bit.
module fpa_lead_one #(
  parameter int W   = 8,
  parameter int P_W = 3
) (
  input  logic [W-1:0]   din,
  output logic           found,
  output logic [P_W-1:0] pos
);

  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (din[i]) pos = P_W'(i);
    end
  end

  assign found = |din;

endmodule

// File: rtl/fpa_norm.sv
// Carry shift, leading-one renormalize, flush and saturate (R5..R9).
module fpa_norm
  import fpa_pkg::*;
#(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 6
) (
  input  logic                    res_sign,
  input  logic [MANT_W:0]         res_mag,
  input  logic [EXP_W-1:0]        ref_exp,
  output logic [EXP_W+MANT_W:0]   sum_word
);

  localparam int SHA_W = (MANT_W > 1) ? $clog2(MANT_W) : 1;

  logic              carry;
  logic              found;
  logic [SHA_W-1:0]  top_pos;
  logic [SHA_W-1:0]  lz;
  logic [MANT_W-1:0] left_mant;
  logic [EXP_W:0]    exp_up;
  logic [EXP_W-1:0]  exp_dn;
  logic              underflow;
  res_kind_e         kind;

  assign carry = res_mag[MANT_W];

  fpa_lead_one #(
    .W  (MANT_W),
    .P_W(SHA_W)
  ) u_lead (
    .din  (res_mag[MANT_W-1:0]),
    .found(found),
    .pos  (top_pos)
  );

  assign lz = SHA_W'(MANT_W - 1) - top_pos;

  fpa_shift #(
    .W   (MANT_W),
    .SH_W(SHA_W),
    .LEFT(1'b1)
  ) u_renorm (
    .din (res_mag[MANT_W-1:0]),
    .amt (lz),
    .dout(left_mant)
  );

  assign exp_up    = {1'b0, ref_exp} + 1'b1;
  assign exp_dn    = ref_exp - EXP_W'(lz);
  assign underflow = 32'(ref_exp) <= 32'(lz);

  always_comb begin
    if (carry) begin
      kind = exp_up[EXP_W] ? RES_SAT : RES_NORMAL;
    end else if (!found || underflow) begin
      kind = RES_ZERO;
    end else begin
      kind = RES_NORMAL;
    end
  end

  always_comb begin
    case (kind)
      RES_ZERO: sum_word = '0;
      RES_SAT:  sum_word = {res_sign, {EXP_W{1'b1}}, {MANT_W{1'b1}}};
      default: begin
        if (carry) sum_word = {res_sign, exp_up[EXP_W-1:0], res_mag[MANT_W:1]};
        else       sum_word = {res_sign, exp_dn, left_mant};
      end
    endcase
  end

endmodule

// File: rtl/fpa_adder.sv
// Floating-point adder with valid/ready stream edges and one output register.
module fpa_adder #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [EXP_W+MANT_W:0]     in_a,
  input  logic [EXP_W+MANT_W:0]     in_b,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [EXP_W+MANT_W:0]     out_sum
);

  localparam int W = 1 + EXP_W + MANT_W;

  logic              big_sign;
  logic [EXP_W-1:0]  big_exp;
  logic [MANT_W-1:0] big_mant;
  logic              small_sign;
  logic [MANT_W-1:0] small_al;
  logic              res_sign;
  logic [MANT_W:0]   res_mag;
  logic [W-1:0]      next_sum;

  fpa_order_align #(
    .MANT_W(MANT_W),
    .EXP_W (EXP_W)
  ) u_order (
    .a_sign    (in_a[W-1]),
    .a_exp     (in_a[W-2:MANT_W]),
    .a_mant    (in_a[MANT_W-1:0]),
    .b_sign    (in_b[W-1]),
    .b_exp     (in_b[W-2:MANT_W]),
    .b_mant    (in_b[MANT_W-1:0]),
    .big_sign  (big_sign),
    .big_exp   (big_exp),
    .big_mant  (big_mant),
    .small_sign(small_sign),
    .small_al  (small_al)
  );

  fpa_mant_addsub #(
    .MANT_W(MANT_W)
  ) u_addsub (
    .big_sign  (big_sign),
    .big_mant  (big_mant),
    .small_sign(small_sign),
    .small_al  (small_al),
    .res_sign  (res_sign),
    .res_mag   (res_mag)
  );

  fpa_norm #(
    .MANT_W(MANT_W),
    .EXP_W (EXP_W)
  ) u_norm (
    .res_sign(res_sign),
    .res_mag (res_mag),
    .ref_exp (big_exp),
    .sum_word(next_sum)
  );

  // R10: take a new pair whenever the held result is empty or leaving
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_sum <= next_sum;
    end
  end

endmodule

// File: rtl/fpa_adder_chk.sv
module fpa_adder_chk #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [EXP_W+MANT_W:0] in_a,
  input logic [EXP_W+MANT_W:0] in_b,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [EXP_W+MANT_W:0] out_sum
);

  localparam int W = 1 + EXP_W + MANT_W;

  logic [31:0] a_exp32;
  logic [31:0] b_exp32;
  logic        a_far_ahead;

  assign a_exp32     = 32'(in_a[W-2:MANT_W]);
  assign b_exp32     = 32'(in_b[W-2:MANT_W]);
  assign a_far_ahead = in_a[MANT_W-1] && (a_exp32 >= b_exp32 + 32'(MANT_W));

  assert_accept_to_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sum));

  assert_ready_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_normalized_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sum[MANT_W-1] || (out_sum == '0));

  assert_zero_encoding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_sum[MANT_W-1:0] == '0) |-> out_sum == '0);

  assert_far_gap_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && a_far_ahead |=> out_sum == $past(in_a));

  always_comb begin
    if (!rst_n) assert_reset_idle_R11: assert (in_ready);
  end

endmodule

bind fpa_adder fpa_adder_chk #(
  .MANT_W(MANT_W),
  .EXP_W (EXP_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_a     (in_a),
  .in_b     (in_b),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_sum  (out_sum)
);

// File: tb/fpa_adder_tb.sv
module fpa_adder_tb;

  localparam int MW = 8;
  localparam int EW = 6;
  localparam int W  = 1 + EW + MW;
  localparam int NV = 19;

  // Each entry: {a, b, expected sum}; words are {sign, exp, mant}, bias 31
  localparam logic [3*W-1:0] VEC [NV] = '{
    {1'b0,6'd31,8'h80, 1'b0,6'd31,8'h80, 1'b0,6'd32,8'h80}, // R5 1+1
    {1'b0,6'd31,8'hC0, 1'b0,6'd31,8'hA0, 1'b0,6'd32,8'hB0}, // R5 1.5+1.25
    {1'b0,6'd31,8'h80, 1'b0,6'd29,8'h80, 1'b0,6'd31,8'hA0}, // R2 gap 2
    {1'b0,6'd29,8'h80, 1'b0,6'd31,8'h80, 1'b0,6'd31,8'hA0}, // R1 swapped order
    {1'b0,6'd31,8'hC0, 1'b1,6'd31,8'h80, 1'b0,6'd30,8'h80}, // R6 1.5-1
    {1'b0,6'd31,8'h80, 1'b1,6'd31,8'hC0, 1'b1,6'd30,8'h80}, // R4 negative sum
    {1'b0,6'd31,8'hA5, 1'b1,6'd31,8'hA5, 1'b0,6'd0, 8'h00}, // R7 cancel
    {1'b0,6'd40,8'h80, 1'b0,6'd32,8'hFF, 1'b0,6'd40,8'h80}, // R3 gap 8
    {1'b1,6'd50,8'hC3, 1'b0,6'd30,8'hFF, 1'b1,6'd50,8'hC3}, // R3 gap 20
    {1'b0,6'd31,8'h80, 1'b0,6'd30,8'h81, 1'b0,6'd31,8'hC0}, // R2 lsb dropped
    {1'b0,6'd31,8'hFF, 1'b0,6'd31,8'h81, 1'b0,6'd32,8'hC0}, // R5 carry truncates
    {1'b0,6'd31,8'h81, 1'b1,6'd31,8'h80, 1'b0,6'd24,8'h80}, // R6 shift 7
    {1'b0,6'd3, 8'h81, 1'b1,6'd3, 8'h80, 1'b0,6'd0, 8'h00}, // R8 flush
    {1'b0,6'd8, 8'h81, 1'b1,6'd8, 8'h80, 1'b0,6'd1, 8'h80}, // R8 lowest exp kept
    {1'b0,6'd7, 8'h81, 1'b1,6'd7, 8'h80, 1'b0,6'd0, 8'h00}, // R8 just below
    {1'b0,6'd63,8'h80, 1'b0,6'd63,8'h80, 1'b0,6'd63,8'hFF}, // R9 saturate
    {1'b1,6'd31,8'h80, 1'b1,6'd31,8'h80, 1'b1,6'd32,8'h80}, // R4 both negative
    {1'b0,6'd0, 8'h00, 1'b1,6'd33,8'h90, 1'b1,6'd33,8'h90}, // R1 zero operand
    {1'b1,6'd33,8'h80, 1'b0,6'd32,8'h80, 1'b1,6'd32,8'h80}  // R4 aligned subtract
  };
  localparam int VTAG [NV] = '{5,5,2,1,6,4,7,3,3,2,5,6,8,8,8,9,4,1,4};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [W-1:0] in_a;
  logic [W-1:0] in_b;
  logic         out_valid;
  logic         out_ready;
  logic [W-1:0] out_sum;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fpa_adder #(
    .MANT_W(MW),
    .EXP_W (EW)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_a     (in_a),
    .in_b     (in_b),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_sum  (out_sum)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  task automatic send_one(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] want,
                          input int tag);
    @(negedge clk);
    in_a     = a;
    in_b     = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check($sformatf("R%0d valid", tag), W'(out_valid), W'(1));
    check($sformatf("R%0d sum", tag), out_sum, want);
  endtask

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    out_ready = 1'b1;
    in_a      = '0;
    in_b      = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 out_valid in reset", W'(out_valid), W'(0));
    check("R11 in_ready in reset", W'(in_ready), W'(1));
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send_one(VEC[i][3*W-1:2*W], VEC[i][2*W-1:W], VEC[i][W-1:0], VTAG[i]);
    end
    @(negedge clk);
    check("R10 valid drops when idle", W'(out_valid), W'(0));

    // R10 back-pressure: result held, input stalled, then both move
    out_ready = 1'b0;
    in_a      = VEC[0][3*W-1:2*W];
    in_b      = VEC[0][2*W-1:W];
    in_valid  = 1'b1;
    @(negedge clk);
    in_a = VEC[1][3*W-1:2*W];
    in_b = VEC[1][2*W-1:W];
    check("R10 in_ready low when blocked", W'(in_ready), W'(0));
    check("R10 first result", out_sum, VEC[0][W-1:0]);
    @(negedge clk);
    check("R10 held valid", W'(out_valid), W'(1));
    check("R10 held result", out_sum, VEC[0][W-1:0]);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second result after release", out_sum, VEC[1][W-1:0]);
    check("R10 second valid", W'(out_valid), W'(1));
    @(negedge clk);
    check("R10 drained", W'(out_valid), W'(0));

    // R11 reset in the middle of traffic
    in_a     = VEC[2][3*W-1:2*W];
    in_b     = VEC[2][2*W-1:W];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    #1;
    check("R11 reset clears valid", W'(out_valid), W'(0));
    check("R11 reset ready", W'(in_ready), W'(1));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule